// File: doc/BRIEF.md
# ROM-Based Next-Address Microsequencer

This block is a microprogrammed controller with no sequencing logic. It has an internal control store of 2^n microwords and an n-bit address register. Each microword carries two fields. The upper field holds the control bits the block drives out. The lower field names the word to run next. On every clock the register takes the next-address field of the word it currently points at. The microprogram can therefore occupy any locations, in any order, provided each word points to its successor.

The control store is read combinationally from the register. The control outputs of a word appear in the same cycle that its address is held. A synchronous reset clears the register, so execution always starts at address 0. A small write port loads microcode into the store. It takes effect only while reset is asserted, so the program cannot change while the sequencer runs. Exactly one sequence exists, and it repeats forever once it points back to an earlier word. The current address is an output so that the execution path can be traced.

Top module: `ucs_microseq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cur_addr` becomes 0. After that edge, `ctrl_out` shows the control field of word 0.
- R2: At every rising edge with `rst` low, `cur_addr` takes bits [ADDR_W-1:0] of the word stored at the previous `cur_addr`. No enable gates this load.
- R3: `ctrl_out` always equals bits [ADDR_W+CTRL_W-1:ADDR_W] of the word at the current `cur_addr`, in the same cycle, with no clock delay.
- R4: A rising edge with `rst` and `ld_en` both high stores `ld_word` at location `ld_addr`. The stored word is used once reset is released.
- R5: `ld_en` has no effect while `rst` is low. The stored program, the address sequence and `ctrl_out` all stay as they would be without it.
- R6: A microprogram may use any locations in any order. A word whose next-address field equals its own address holds `cur_addr` constant for as long as reset stays low.
- R7: All 2^ADDR_W locations can be written and executed, including the highest address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the write port |
| ld_en | input | 1 | Write request for the control store |
| ld_addr | input | ADDR_W | Location to write |
| ld_word | input | ADDR_W+CTRL_W | Microword to write: control bits on top, next address at the bottom |
| ctrl_out | output | CTRL_W | Control field of the current microword |
| cur_addr | output | ADDR_W | Address currently held in the register |

## Verification
The bench uses the default parameters: a 4-bit address and an 8-bit control field, so the store holds 16 words. This is small enough to fill completely. One program visits all 16 locations in a scrambled full-period order, which exercises every word, both field boundaries and the top address. Further programs cover a short loop that starts away from the bottom of memory, a self-loop, and writes attempted while the sequencer runs. Each expected address and control value is computed arithmetically from the program formula.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  // Extract the next-address field (low bits) of a microword.
  function automatic logic [15:0] next_field(input logic [63:0] word, input int aw);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < aw) r[i] = word[i];
    end
    return r;
  endfunction

  // Extract the control field (bits above the next-address field).
  function automatic logic [47:0] ctrl_field(input logic [63:0] word, input int aw, input int cw);
    logic [47:0] r;
    r = '0;
    for (int i = 0; i < 48; i++) begin
      if (i < cw) r[i] = word[i + aw];
    end
    return r;
  endfunction

endpackage

// File: rtl/ucs_ctrl_store.sv
module ucs_ctrl_store #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Combinational read from the address register.
  assign rdata = mem[raddr];
endmodule

// File: rtl/ucs_field_split.sv
module ucs_field_split
  import ucs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 8,
  localparam int WORD_W = ADDR_W + CTRL_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] next_addr,
  output logic [CTRL_W-1:0] ctrl
);
  logic [63:0] wide;
  logic [15:0] nx;
  logic [47:0] cf;

  always_comb begin
    wide = '0;
    wide[WORD_W-1:0] = word;
    nx = next_field(wide, ADDR_W);
    cf = ctrl_field(wide, ADDR_W, CTRL_W);
  end

  assign next_addr = nx[ADDR_W-1:0];
  assign ctrl      = cf[CTRL_W-1:0];
endmodule

// File: rtl/ucs_addr_reg.sv
module ucs_addr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  // Loads every edge; reset forces the start address.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/ucs_microseq.sv
module ucs_microseq #(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 8,
  localparam int WORD_W = ADDR_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [ADDR_W-1:0] cur_addr
);
  logic              wr_fire;
  logic [WORD_W-1:0] cur_word;
  logic [ADDR_W-1:0] nxt_addr;

  // Write port opens only while the sequencer is held in reset.
  assign wr_fire = ld_en & rst;

  ucs_ctrl_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (ld_addr),
    .wdata (ld_word),
    .raddr (cur_addr),
    .rdata (cur_word)
  );

  ucs_field_split #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_split (
    .word      (cur_word),
    .next_addr (nxt_addr),
    .ctrl      (ctrl_out)
  );

  ucs_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk (clk),
    .rst (rst),
    .d   (nxt_addr),
    .q   (cur_addr)
  );
endmodule

// File: rtl/ucs_microseq_chk.sv
module ucs_microseq_chk #(
  parameter int ADDR_W = 4,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] nxt_addr,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic [ADDR_W-1:0] cur_addr
);
  // R1: a reset edge leaves the register at the start address
  p_reset_start_r1: assert property (@(posedge clk) rst |=> (cur_addr == '0));

  // R2: the register follows the split-off next-address field
  p_follow_next_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (cur_addr == $past(nxt_addr)));

  // R3: with address and store unchanged, the control field is unchanged
  p_ctrl_steady_r3: assert property (@(posedge clk) disable iff (rst)
    ($stable(cur_addr) && !$past(wr_fire)) |-> $stable(ctrl_out));

  // R6: a self-pointing word holds the address
  p_self_loop_r6: assert property (@(posedge clk) disable iff (rst)
    (nxt_addr == cur_addr) |=> $stable(cur_addr));
endmodule

bind ucs_microseq ucs_microseq_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_fire  (wr_fire),
  .nxt_addr (nxt_addr),
  .ctrl_out (ctrl_out),
  .cur_addr (cur_addr)
);

// File: tb/sim_ucs_microseq.sv
module sim_ucs_microseq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int WW = AW + CW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [WW-1:0] ld_word = '0;
  logic [CW-1:0] ctrl_out;
  logic [AW-1:0] cur_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Model of the loaded program, kept by the bench.
  int prog_next [DEPTH];
  int prog_ctrl [DEPTH];

  ucs_microseq #(.ADDR_W(AW), .CTRL_W(CW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_word(ld_word), .ctrl_out(ctrl_out), .cur_addr(cur_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Write one word under reset and record it in the model.
  task automatic put(input int a, input int nx, input int cf);
    rst = 1'b1;
    ld_en = 1'b1;
    ld_addr = AW'(a);
    ld_word = {CW'(cf), AW'(nx)};
    prog_next[a] = nx;
    prog_ctrl[a] = cf;
    tick();
    ld_en = 1'b0;
  endtask

  // Release reset and follow the program for n cycles.
  task automatic run(input int n, input string req);
    int e;
    rst = 1'b0;
    e = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      e = prog_next[e];
      check({req, " addr"}, int'(cur_addr), e);
      check({req, " ctrl"}, int'(ctrl_out), prog_ctrl[e]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    // R7/R4: full-period scrambled program over all 16 words
    for (int a = 0; a < DEPTH; a++) put(a, (a * 5 + 3) % DEPTH, (a * 37 + 90) % 256);
    tick();
    // R1: reset state
    check("R1 addr", int'(cur_addr), 0);
    check("R1 ctrl", int'(ctrl_out), prog_ctrl[0]);
    // R2/R3/R7: two full trips through every location
    run(2 * DEPTH + 3, "R2 R3 R7");

    // R5: writes while running are ignored; every location is targeted
    begin
      int e;
      e = prog_next[prog_next[prog_next[2 * DEPTH + 3 > 0 ? 0 : 0]]];
      e = 0;
      for (int i = 0; i < 2 * DEPTH + 3; i++) e = prog_next[e];
      for (int i = 0; i < 2 * DEPTH; i++) begin
        ld_en = 1'b1;
        ld_addr = AW'(i % DEPTH);
        ld_word = {CW'(8'hFF), AW'(i % DEPTH)};
        tick();
        e = prog_next[e];
        check("R5 addr", int'(cur_addr), e);
        check("R5 ctrl", int'(ctrl_out), prog_ctrl[e]);
      end
      ld_en = 1'b0;
    end
    // R5: after reset, original program still intact
    rst = 1'b1;
    tick();
    check("R5 reset ctrl", int'(ctrl_out), prog_ctrl[0]);
    run(DEPTH, "R5 intact");

    // R6/R4: short loop 0 -> 9 -> 2 -> 15 -> 9 ...
    put(0, 9, 8'h11);
    put(9, 2, 8'h22);
    put(2, 15, 8'h44);
    put(15, 9, 8'h88);
    tick();
    check("R1 ctrl reload", int'(ctrl_out), 8'h11);
    run(12, "R6 loop");

    // R6: self-loop at the top address
    put(0, 15, 8'hA5);
    put(15, 15, 8'h3C);
    tick();
    run(10, "R6 self");
    check("R6 hold", int'(cur_addr), 15);

    // R1: reset mid-run returns to word 0
    rst = 1'b1;
    tick();
    check("R1 mid-run addr", int'(cur_addr), 0);
    check("R1 mid-run ctrl", int'(ctrl_out), 8'hA5);

    finish_run();
  end
endmodule